// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns the command, address and control pins of a four-bank, 16-bit synchronous DRAM from reset until the memory can take normal traffic. Coming out of reset, it keeps clock enable and both byte masks high and sends only no-operation commands for a stabilisation window. The window's length in cycles is the product of a clock-frequency parameter (MHz) and an idle-time parameter (microseconds). After the window it sends one all-bank precharge. It then sends a parameterised number of auto-refresh commands, at least two, and a single mode register load. A configuration bit can move the mode load ahead of the refreshes. Each command is followed by its own parameterised run of no-operation cycles.

The mode word is assembled from four configuration inputs: burst length code, interleaved ordering, CAS latency code and single-location write. If these inputs describe a reserved or illegal combination, the block loads a safe default word instead and raises a sticky configuration-error flag. One cycle after the last wait has run out, the block raises a done flag. From then on it keeps the bus at no-operation until the next reset. Normal reads, writes and periodic refresh belong to a downstream controller that takes over the pins once done is high.

Top module: `sdram_bringup_seq`

## Requirements
- R1: While reset is asserted, and on every cycle after it, `sd_cke` is 1 and every bit of `sd_dqm` is 1. In reset the command is no-operation, which is {cs_n,ras_n,cas_n,we_n} = 0111.
- R2: Counting the first cycle after reset release as cycle 0, the bus carries no-operation for exactly CLK_MHZ*IDLE_US cycles. The first command is precharge (0010) with `sd_addr[10]` = 1, meaning all banks.
- R3: A precharge is followed by exactly T_RP_CYC no-operation cycles before the next command.
- R4: Exactly REFRESH_CNT auto-refresh commands (0001) are issued. Each is followed by exactly T_RFC_CYC no-operation cycles before the next command or before done.
- R5: The mode load (0000) puts burst length code on `sd_addr[2:0]`, interleave on bit 3 and CAS latency code on bits 6:4. Bits 8:7, bits 11:10 and `sd_ba` are all 0.
- R6: With `cfg_mrs_first` = 0 the order is precharge, all refreshes, then mode load. With it at 1 the order is precharge, mode load, then all refreshes.
- R7: Burst length codes 0..3 are legal, and code 7 (full page) is legal only when interleave is 0. CAS codes 2 and 3 are legal. For any other input combination the mode word is 0x020 (length 1, sequential, latency 2, bit 9 clear). In that case `cfg_error` rises in the cycle after the mode load and stays high until reset. For legal inputs it stays 0.
- R8: A mode load is followed by exactly T_MRD_CYC no-operation cycles before the next command or before done.
- R9: `init_done` rises in the cycle after the final wait ends and stays high until reset. While it is high, every command is no-operation.
- R10: `sd_addr[9]` during a legal mode load equals `cfg_single_write`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code |
| cfg_interleave | input | 1 | 1 = interleaved burst ordering |
| cfg_cas_lat | input | 3 | CAS latency code |
| cfg_single_write | input | 1 | 1 = burst reads with single-location writes |
| cfg_mrs_first | input | 1 | 1 = load mode before the refreshes |
| sd_cke | output | 1 | Clock enable |
| sd_dqm | output | 2 | Byte masks |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Address / mode word |
| init_done | output | 1 | Bring-up complete |
| cfg_error | output | 1 | Illegal configuration was substituted |

## Verification
The bench resets the block once for every combination of burst code, ordering, latency code, write mode and order swap, and records the cycle of every command. An off-by-one in any wait counter would shift one command, and every command after it, by a cycle. A refresh counter loaded one short or one long would change the number of refreshes. A swap that was ignored would put the mode load in the wrong slot. Full page with interleave, the reserved burst codes 4 to 6 and the unused latency codes are each checked. A design that passed one of them through, or flagged a legal combination such as full page with sequential ordering, would show the wrong word on the address pins or the wrong error flag.

// File: rtl/sdram_bringup_pkg.sv
// Shared encodings for the SDRAM bring-up sequencer.
// Command codes are {cs_n, ras_n, cas_n, we_n}.
package sdram_bringup_pkg;

    typedef enum logic [3:0] {
        SD_NOP = 4'b0111,
        SD_PRE = 4'b0010,
        SD_REF = 4'b0001,
        SD_MRS = 4'b0000
    } sd_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF,
        ST_WAIT_RFC,
        ST_MRS,
        ST_WAIT_MRD,
        ST_DONE
    } seq_state_e;

    localparam int MODE_W = 12;

    // Fallback word: length 1, sequential, latency 2.
    localparam logic [MODE_W-1:0] SAFE_MODE = 12'h020;

endpackage

// File: rtl/sdram_mode_word.sv
// Builds the mode register word from the configuration inputs and judges it.
// Assumes the inputs are held stable across the mode-load cycle.
module sdram_mode_word
    import sdram_bringup_pkg::*;
(
    input  logic [2:0]        burst_code,
    input  logic              interleave,
    input  logic [2:0]        cas_code,
    input  logic              single_write,
    output logic [MODE_W-1:0] word,
    output logic              legal
);

    logic burst_ok;
    logic cas_ok;

    // Legality of each field and selection of the word to be loaded.
    always_comb begin
        burst_ok = (burst_code <= 3'd3) || ((burst_code == 3'd7) && !interleave);
        cas_ok   = (cas_code == 3'd2) || (cas_code == 3'd3);
        legal    = burst_ok && cas_ok;
        if (legal) begin
            word = {2'b00, single_write, 2'b00, cas_code, interleave, burst_code};
        end else begin
            word = SAFE_MODE;
        end
    end

endmodule

// File: rtl/bringup_timer.sv
// Down-counter for the wait phases. It starts at RST_VAL on reset, reloads
// when asked, and stops at zero. `expired` is high while the count is zero.
module bringup_timer #(
    parameter int CNT_W   = 16,
    parameter int RST_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    // Reload or count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/sdram_bringup_seq.sv
// Power-up sequencer for a four-bank SDRAM. It holds the bus idle, then sends
// an all-bank precharge, REFRESH_CNT auto-refreshes and a mode load, each
// followed by its wait, and finally raises init_done.
// Assumptions: all wait parameters are at least 1, REFRESH_CNT is at least 2,
// and the cfg_* inputs are stable from reset release until init_done.
module sdram_bringup_seq
    import sdram_bringup_pkg::*;
#(
    parameter int CLK_MHZ     = 100,
    parameter int IDLE_US     = 200,
    parameter int T_RP_CYC    = 3,
    parameter int T_RFC_CYC   = 7,
    parameter int T_MRD_CYC   = 2,
    parameter int REFRESH_CNT = 2,
    parameter int DQM_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_single_write,
    input  logic              cfg_mrs_first,
    output logic              sd_cke,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [1:0]        sd_ba,
    output logic [MODE_W-1:0] sd_addr,
    output logic              init_done,
    output logic              cfg_error
);

    localparam int T_IDLE   = CLK_MHZ * IDLE_US;
    localparam int MAX_A    = (T_RP_CYC > T_RFC_CYC) ? T_RP_CYC : T_RFC_CYC;
    localparam int MAX_B    = (MAX_A > T_MRD_CYC) ? MAX_A : T_MRD_CYC;
    localparam int MAX_WAIT = (MAX_B > T_IDLE) ? MAX_B : T_IDLE;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int REF_W    = $clog2(REFRESH_CNT + 1);

    seq_state_e        state;
    seq_state_e        state_nx;
    sd_cmd_e           cmd;
    logic              swap_q;
    logic [REF_W-1:0]  ref_left;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic [MODE_W-1:0] mode_word;
    logic              mode_legal;

    sdram_mode_word u_mode (
        .burst_code   (cfg_burst_len),
        .interleave   (cfg_interleave),
        .cas_code     (cfg_cas_lat),
        .single_write (cfg_single_write),
        .word         (mode_word),
        .legal        (mode_legal)
    );

    bringup_timer #(
        .CNT_W   (CNT_W),
        .RST_VAL (T_IDLE - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_zero)
    );

    // Next-state selection for the bring-up order.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (tmr_zero) state_nx = ST_PRE;
            ST_PRE:      state_nx = ST_WAIT_RP;
            ST_WAIT_RP:  if (tmr_zero) state_nx = swap_q ? ST_MRS : ST_REF;
            ST_REF:      state_nx = ST_WAIT_RFC;
            ST_WAIT_RFC: if (tmr_zero) begin
                             if (ref_left != '0) state_nx = ST_REF;
                             else                state_nx = swap_q ? ST_DONE : ST_MRS;
                         end
            ST_MRS:      state_nx = ST_WAIT_MRD;
            ST_WAIT_MRD: if (tmr_zero) state_nx = swap_q ? ST_REF : ST_DONE;
            ST_DONE:     state_nx = ST_DONE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Timer reload on each command cycle, with that command's wait length.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state)
            ST_PRE: begin tmr_load = 1'b1; tmr_val = CNT_W'(T_RP_CYC - 1);  end
            ST_REF: begin tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC_CYC - 1); end
            ST_MRS: begin tmr_load = 1'b1; tmr_val = CNT_W'(T_MRD_CYC - 1); end
            default: ;
        endcase
    end

    // State register, order latch, refresh budget and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            swap_q    <= 1'b0;
            ref_left  <= '0;
            cfg_error <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_PRE) begin
                swap_q   <= cfg_mrs_first;
                ref_left <= REF_W'(REFRESH_CNT);
            end
            if (state == ST_REF) ref_left <= ref_left - 1'b1;
            if ((state == ST_MRS) && !mode_legal) cfg_error <= 1'b1;
        end
    end

    // Pin decode from the current state.
    always_comb begin
        cmd     = SD_NOP;
        sd_addr = '0;
        case (state)
            ST_PRE: begin cmd = SD_PRE; sd_addr[10] = 1'b1; end
            ST_REF: cmd = SD_REF;
            ST_MRS: begin cmd = SD_MRS; sd_addr = mode_word; end
            default: ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke    = 1'b1;
    assign sd_dqm    = '1;
    assign sd_ba     = 2'b00;
    assign init_done = (state == ST_DONE);

    // R2
    pre_all_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SD_PRE) |-> sd_addr[10]);

    // R5
    mrs_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SD_MRS) |-> (sd_ba == 2'b00 && sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00));

    // R3
    cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != SD_NOP) |=> (cmd == SD_NOP));

    // R4
    ref_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == SD_REF) |-> (ref_left != '0));

    // R9
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    // R9
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == SD_NOP));

    // R7
    cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> cfg_error);

endmodule

// File: tb/sdram_bringup_seq_bench.sv
// Sweeps every configuration input combination through a full bring-up and
// checks command order, command cycles, mode word and flags.
module sdram_bringup_seq_bench;

    localparam int PERIOD = 10;
    localparam int MHZ    = 1;
    localparam int IDLE   = 20;
    localparam int TRP    = 3;
    localparam int TRFC   = 5;
    localparam int TMRD   = 2;
    localparam int NREF   = 3;
    localparam int TIDLE  = MHZ * IDLE;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_burst_len = '0;
    logic        cfg_interleave = 1'b0;
    logic [2:0]  cfg_cas_lat = 3'd2;
    logic        cfg_single_write = 1'b0;
    logic        cfg_mrs_first = 1'b0;
    logic        sd_cke;
    logic [1:0]  sd_dqm;
    logic        sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [11:0] sd_addr;
    logic        init_done;
    logic        cfg_error;

    int vectors = 0;
    int errors  = 0;

    always #(PERIOD/2) clk = ~clk;

    sdram_bringup_seq #(
        .CLK_MHZ     (MHZ),
        .IDLE_US     (IDLE),
        .T_RP_CYC    (TRP),
        .T_RFC_CYC   (TRFC),
        .T_MRD_CYC   (TMRD),
        .REFRESH_CNT (NREF),
        .DQM_W       (2)
    ) u_sdram_bringup_seq (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_burst_len    (cfg_burst_len),
        .cfg_interleave   (cfg_interleave),
        .cfg_cas_lat      (cfg_cas_lat),
        .cfg_single_write (cfg_single_write),
        .cfg_mrs_first    (cfg_mrs_first),
        .sd_cke           (sd_cke),
        .sd_dqm           (sd_dqm),
        .sd_cs_n          (sd_cs_n),
        .sd_ras_n         (sd_ras_n),
        .sd_cas_n         (sd_cas_n),
        .sd_we_n          (sd_we_n),
        .sd_ba            (sd_ba),
        .sd_addr          (sd_addr),
        .init_done        (init_done),
        .cfg_error        (cfg_error)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_one(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                           input logic wbl, input logic swap);
        int e_code [8];
        int e_cyc  [8];
        int r_code [8];
        int r_cyc  [8];
        int r_addr [8];
        int r_ba   [8];
        int e_n, e_done, t, n, done_cyc, bad_pin, drop, post, err_early, mrs_cyc;
        int exp_word;
        bit legal;
        logic [3:0] cmd;

        rst_n            = 1'b0;
        cfg_burst_len    = bl;
        cfg_interleave   = bt;
        cfg_cas_lat      = cl;
        cfg_single_write = wbl;
        cfg_mrs_first    = swap;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111 && sd_cke && sd_dqm == 2'b11,
            "R1 reset pins", {sd_cke, sd_dqm, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7'h77);
        chk(!init_done && !cfg_error, "R9 R7 flags in reset", {init_done, cfg_error}, 0);

        // Expected schedule
        legal = ((bl <= 3'd3) || (bl == 3'd7 && !bt)) && (cl == 3'd2 || cl == 3'd3);
        exp_word = legal ? ((int'(wbl) << 9) | (int'(cl) << 4) | (int'(bt) << 3) | int'(bl)) : 32;
        t = TIDLE;
        e_n = 0;
        e_code[e_n] = 4'b0010; e_cyc[e_n] = t; e_n++; t += 1 + TRP;
        mrs_cyc = 0;
        if (swap) begin
            e_code[e_n] = 4'b0000; e_cyc[e_n] = t; mrs_cyc = t; e_n++; t += 1 + TMRD;
        end
        for (int k = 0; k < NREF; k++) begin
            e_code[e_n] = 4'b0001; e_cyc[e_n] = t; e_n++; t += 1 + TRFC;
        end
        if (!swap) begin
            e_code[e_n] = 4'b0000; e_cyc[e_n] = t; mrs_cyc = t; e_n++; t += 1 + TMRD;
        end
        e_done = t;

        n = 0; done_cyc = -1; bad_pin = 0; drop = 0; post = 0; err_early = 0;
        for (int k = 0; k < 8; k++) begin
            r_code[k] = 0; r_cyc[k] = 0; r_addr[k] = 0; r_ba[k] = 0;
        end
        rst_n = 1'b1;
        for (int c = 0; c <= e_done + 6; c++) begin
            cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            if (!sd_cke || sd_dqm != 2'b11) bad_pin++;
            if (cmd != 4'b0111 && n < 8) begin
                r_code[n] = int'(cmd); r_cyc[n] = c;
                r_addr[n] = int'(sd_addr); r_ba[n] = int'(sd_ba);
                n++;
            end
            if (cfg_error && c <= mrs_cyc) err_early++;
            if (init_done && done_cyc < 0) done_cyc = c;
            if (done_cyc >= 0 && !init_done) drop++;
            if (init_done && cmd != 4'b0111) post++;
            @(negedge clk);
        end

        chk(bad_pin == 0, "R1 cke/dqm high", bad_pin, 0);
        chk(n == e_n, "R4 command count", n, e_n);
        for (int k = 0; k < e_n; k++) begin
            chk(r_code[k] == e_code[k], "R6 command order", r_code[k], e_code[k]);
            if (k == 0)
                chk(r_cyc[k] == e_cyc[k], "R2 idle length", r_cyc[k], e_cyc[k]);
            else if (e_code[k-1] == 4'b0010)
                chk(r_cyc[k] == e_cyc[k], "R3 precharge wait", r_cyc[k], e_cyc[k]);
            else if (e_code[k-1] == 4'b0001)
                chk(r_cyc[k] == e_cyc[k], "R4 refresh wait", r_cyc[k], e_cyc[k]);
            else
                chk(r_cyc[k] == e_cyc[k], "R8 mode wait", r_cyc[k], e_cyc[k]);
            if (e_code[k] == 4'b0010)
                chk(r_addr[k][10] == 1'b1, "R2 all-bank bit", r_addr[k], 1024);
            if (e_code[k] == 4'b0000) begin
                if (legal)
                    chk(r_addr[k] == exp_word, "R5 R10 mode word", r_addr[k], exp_word);
                else
                    chk(r_addr[k] == exp_word, "R7 safe mode word", r_addr[k], exp_word);
                chk(r_ba[k] == 0, "R5 bank bits zero", r_ba[k], 0);
            end
        end
        chk(done_cyc == e_done, "R9 done cycle", done_cyc, e_done);
        chk(drop == 0 && post == 0, "R9 done sticky and quiet", drop + post, 0);
        chk(cfg_error == !legal, "R7 error flag", int'(cfg_error), int'(!legal));
        chk(err_early == 0, "R7 error not early", err_early, 0);
    endtask

    initial begin
        for (int bl = 0; bl < 8; bl++)
            for (int bt = 0; bt < 2; bt++)
                for (int cl = 0; cl < 8; cl++)
                    for (int wbl = 0; wbl < 2; wbl++)
                        for (int sw = 0; sw < 2; sw++)
                            run_one(3'(bl), 1'(bt), 3'(cl), 1'(wbl), 1'(sw));
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 190000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule